// File: doc/BRIEF.md
# ISA Command-Strobe Address Capture

This block sits at the bus edge of an 8-bit ISA add-in card. It decides which address belongs to each memory or I/O access from the host. It does not use the address-latch pulse, because the host can emit that pulse while a refresh or DMA transfer is driving the address lines. Instead, it takes the address at the moment a command strobe is seen active, and only if the DMA-owns-bus signal (AEN) is low.

The four active-low strobes and AEN each pass through a two-flop synchroniser into the system clock. The first synchronised cycle in which exactly one strobe is active and AEN is low captures the address lines. That captured address is compared with a programmable base under a mask. On a match, the block updates its captured address and its direction and space flags, and raises a one-cycle valid pulse. If several strobes are active at the same moment, the block raises a one-cycle error pulse and discards the access. After any capture, the block waits until every strobe has returned high before it will take another access.

Top module: `isa_cmd_capture`

## Requirements
- R1: After reset, acc_valid and acc_err are 0, cap_addr is all zeros, and cap_write and cap_mem are 0.
- R2: Suppose a single strobe is first sampled low at rising edge k, with AEN low at that edge. Then acc_valid is low after edges k and k+1, and high for the cycle that follows edge k+2.
- R3: cap_addr takes the value on isa_addr at the capture edge, which is the third rising edge of the strobe. Addresses that the bus carried earlier, such as a refresh address, are never used.
- R4: A strobe that is active while the synchronised AEN is high produces no acc_valid pulse and leaves cap_addr unchanged.
- R5: A strobe held low for any number of cycles produces exactly one acc_valid pulse. A new access is accepted once all strobes have been high for at least one synchronised cycle.
- R6: acc_valid fires only when ((isa_addr XOR base_addr) AND addr_mask) is zero. A non-matching access leaves the outputs unchanged.
- R7: On a capture, cap_write is 1 for memw_n or iow_n and 0 for memr_n or ior_n. cap_mem is 1 for memr_n or memw_n and 0 for ior_n or iow_n.
- R8: If two or more strobes are active in the capture cycle, acc_err pulses for one cycle, acc_valid stays low, and cap_addr, cap_write and cap_mem are unchanged.
- R9: cap_addr, cap_write and cap_mem change only in the cycle in which acc_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isa_addr | input | ADDR_W | Bus address lines |
| isa_aen | input | 1 | High while a DMA transfer owns the bus |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| base_addr | input | ADDR_W | Decode base address |
| addr_mask | input | ADDR_W | Bits of the address that take part in the compare |
| cap_addr | output | ADDR_W | Address of the last accepted access |
| cap_write | output | 1 | Last accepted access was a write |
| cap_mem | output | 1 | Last accepted access was to memory space |
| acc_valid | output | 1 | One-cycle pulse for an accepted access |
| acc_err | output | 1 | One-cycle pulse when more than one strobe was active |

## Verification
The assertions assume three things about the inputs:
- isa_addr is stable for the whole time a strobe is low.
- base_addr and addr_mask do not change in the cycle before a capture.
- AEN does not change while a CPU strobe is low.

Under these assumptions, the strobe and AEN history three edges back can be used to judge each valid pulse. The stimulus keeps to these rules: it changes the address, AEN, base and mask only while every strobe is high and the block has settled. A refresh-like case is modelled by asserting AEN and a strobe at a refresh address, and then presenting the CPU address only after AEN has fallen.

// File: rtl/isa_cmd_capture.sv
module isa_cmd_capture #(
  parameter int ADDR_W = 20,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] isa_addr,
  input  logic              isa_aen,
  input  logic              memr_n,
  input  logic              memw_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_write,
  output logic              cap_mem,
  output logic              acc_valid,
  output logic              acc_err
);
  localparam int NCMD = 4;
  localparam int SW   = NCMD + 1;
  localparam logic [SW-1:0] IDLE = {1'b0, {NCMD{1'b1}}};

  logic [SW-1:0] stage [SYNC];
  logic [SW-1:0] raw;
  assign raw = {isa_aen, memr_n, memw_n, ior_n, iow_n};

  for (genvar i = 0; i < SYNC; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      stage[i] <= IDLE;
      else if (i == 0) stage[i] <= raw;
      else             stage[i] <= stage[i-1];
  end

  logic [NCMD-1:0] act;
  logic            aen_s, any, multi, hit, take, armed;

  assign act   = ~stage[SYNC-1][NCMD-1:0];
  assign aen_s = stage[SYNC-1][NCMD];
  assign any   = |act;
  assign multi = (act & (act - 1'b1)) != '0;
  assign hit   = ((isa_addr ^ base_addr) & addr_mask) == '0;
  assign take  = armed && any && !aen_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      acc_valid <= 1'b0;
      acc_err   <= 1'b0;
      cap_addr  <= '0;
      cap_write <= 1'b0;
      cap_mem   <= 1'b0;
    end else begin
      acc_valid <= take && !multi && hit;
      acc_err   <= take && multi;
      if (take)      armed <= 1'b0;
      else if (!any) armed <= 1'b1;
      if (take && !multi && hit) begin
        cap_addr  <= isa_addr;
        cap_write <= act[2] | act[0];
        cap_mem   <= act[3] | act[2];
      end
    end
  end
endmodule

module isa_cmd_capture_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              isa_aen,
  input logic              memw_n,
  input logic              iow_n,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] addr_mask,
  input logic [ADDR_W-1:0] cap_addr,
  input logic              cap_write,
  input logic              acc_valid,
  input logic              acc_err
);
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> !acc_valid);
  // R8
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_err));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> $stable(cap_addr));
  // R6
  decode_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ((cap_addr ^ $past(base_addr)) & $past(addr_mask)) == '0);
  // R4
  aen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !$past(isa_aen, 3));
  // R7
  write_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cap_write) |-> (!$past(memw_n, 3) || !$past(iow_n, 3)));
endmodule

bind isa_cmd_capture isa_cmd_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .isa_aen(isa_aen), .memw_n(memw_n), .iow_n(iow_n),
  .base_addr(base_addr), .addr_mask(addr_mask), .cap_addr(cap_addr),
  .cap_write(cap_write), .acc_valid(acc_valid), .acc_err(acc_err));

// File: tb/sim_isa_cmd_capture.sv
module sim_isa_cmd_capture;
  logic clk = 0, rst_n = 0;
  logic [19:0] isa_addr = '0, base_addr = '0, addr_mask = '0;
  logic isa_aen = 0, memr_n = 1, memw_n = 1, ior_n = 1, iow_n = 1;
  logic [19:0] cap_addr;
  logic cap_write, cap_mem, acc_valid, acc_err;
  int total = 0, bad = 0, vcount = 0, ecount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  isa_cmd_capture u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: inputs seen two edges back decide each edge
  logic [4:0] hist[$];
  bit m_armed = 1, e_valid = 0, e_err = 0, e_wr = 0, e_mem = 0;
  logic [19:0] e_addr = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); m_armed = 1; e_valid = 0; e_err = 0;
      e_wr = 0; e_mem = 0; e_addr = '0;
    end else begin
      logic [4:0] cur;
      int n;
      hist.push_front({isa_aen, ~memr_n, ~memw_n, ~ior_n, ~iow_n});
      cur = (hist.size() >= 3) ? hist[2] : 5'b0;
      if (hist.size() > 3) void'(hist.pop_back());
      n = $countones(cur[3:0]);
      e_valid = 0; e_err = 0;
      if (m_armed && n > 0 && !cur[4]) begin
        m_armed = 0;
        if (n > 1) e_err = 1;
        else if (((isa_addr ^ base_addr) & addr_mask) == 0) begin
          e_valid = 1; e_addr = isa_addr;
          e_wr = cur[2] | cur[0]; e_mem = cur[3] | cur[2];
        end
      end else if (n == 0) m_armed = 1;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(acc_valid == e_valid, "R2 valid", acc_valid, e_valid);
    chk(acc_err == e_err, "R8 err", acc_err, e_err);
    chk(cap_addr == e_addr, "R3 addr", cap_addr, e_addr);
    chk({cap_write, cap_mem} == {e_wr, e_mem}, "R7 kind", {cap_write, cap_mem}, {e_wr, e_mem});
    if (acc_valid) vcount++;
    if (acc_err) ecount++;
  end

  // act bits: [3]=memr [2]=memw [1]=ior [0]=iow
  task automatic drive(input logic [3:0] act, input logic [19:0] a, input bit aen,
                       input int hold, input int gap);
    @(negedge clk);
    isa_addr = a; isa_aen = aen;
    {memr_n, memw_n, ior_n, iow_n} = ~act;
    repeat (hold) @(negedge clk);
    {memr_n, memw_n, ior_n, iow_n} = 4'hF;
    repeat (gap) @(negedge clk);
    isa_aen = 0;
    #1;
  endtask

  initial begin
    int v0, e0;
    repeat (3) @(negedge clk);
    chk({acc_valid, acc_err, cap_write, cap_mem} == 0, "R1 flags", {acc_valid, acc_err, cap_write, cap_mem}, 0);
    chk(cap_addr == 0, "R1 addr", cap_addr, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    base_addr = 20'hC0000; addr_mask = 20'hF8000;
    // R2 latency
    @(negedge clk); isa_addr = 20'hC0123; memr_n = 0;
    @(negedge clk); chk(acc_valid == 0, "R2 edge k", acc_valid, 0);
    @(negedge clk); chk(acc_valid == 0, "R2 edge k+1", acc_valid, 0);
    @(negedge clk); chk(acc_valid == 1, "R2 edge k+2", acc_valid, 1);
    chk(cap_addr == 20'hC0123, "R3 captured", cap_addr, 20'hC0123);
    memr_n = 1; repeat (5) @(negedge clk);

    // R7 memory write
    v0 = vcount; drive(4'b0100, 20'hC7FFF, 0, 3, 6);
    chk(vcount - v0 == 1, "R7 memw pulse", vcount - v0, 1);
    chk(cap_write == 1 && cap_mem == 1, "R7 memw kind", {cap_write, cap_mem}, 2'b11);

    // R6 miss
    v0 = vcount; drive(4'b1000, 20'hD0000, 0, 3, 6);
    chk(vcount == v0, "R6 miss", vcount - v0, 0);
    chk(cap_addr == 20'hC7FFF, "R6 addr kept", cap_addr, 20'hC7FFF);

    // R4 DMA owns the bus, then R3 CPU access at a fresh address
    v0 = vcount; drive(4'b1000, 20'hC4C59, 1, 4, 6);
    chk(vcount == v0, "R4 aen blocks", vcount - v0, 0);
    chk(cap_addr == 20'hC7FFF, "R4 addr kept", cap_addr, 20'hC7FFF);
    drive(4'b1000, 20'hC740B, 0, 3, 6);
    chk(cap_addr == 20'hC740B, "R3 after refresh", cap_addr, 20'hC740B);

    // R5 long hold, then short re-arm gap
    v0 = vcount; drive(4'b1000, 20'hC0010, 0, 12, 1);
    drive(4'b1000, 20'hC0020, 0, 3, 6);
    chk(vcount - v0 == 2, "R5 one per strobe", vcount - v0, 2);

    // I/O space, everything decodes
    base_addr = '0; addr_mask = '0;
    drive(4'b0001, 20'h003C8, 0, 2, 6);
    chk(cap_write == 1 && cap_mem == 0, "R7 iow kind", {cap_write, cap_mem}, 2'b10);
    drive(4'b0010, 20'h003C9, 0, 2, 6);
    chk(cap_write == 0 && cap_mem == 0, "R7 ior kind", {cap_write, cap_mem}, 2'b00);

    // R8 two strobes together
    v0 = vcount; e0 = ecount; drive(4'b1010, 20'h00555, 0, 3, 6);
    chk(ecount - e0 == 1, "R8 err pulse", ecount - e0, 1);
    chk(vcount == v0, "R8 no valid", vcount - v0, 0);
    chk(cap_addr == 20'h003C9, "R9 addr held", cap_addr, 20'h003C9);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule